// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 64-bit virtual address into a 48-bit physical address. It walks a hierarchy of translation tables held in memory with a 4 KB granule. A one-cycle `start` pulse begins a walk. The walker first decides whether the address belongs to the lower or the upper address range, and checks it against that range's configured size. It then fetches one 8-byte descriptor per level through a simple read port: an address pulse out, a data-valid pulse back after any number of cycles.

Each fetched descriptor either points to the next table or ends the walk. A walk ends on a 1 GB or 2 MB block at the middle levels, on a 4 KB page at the last level, or on a fault. When the walk finishes, the block raises `done` for one cycle. It presents the physical address, the final descriptor, a fault class and the level at which the fault was found. These results stay on the outputs until the next walk completes. A request that arrives during a walk is dropped.

Top module: `pt_walker`

## Requirements
- R1: The top address byte selects the table base. A value of 0x00 uses `base_lo` and 0xFF uses `base_hi`. Any other value gives fault code 1 (address size) at level 0, and no memory read is made.
- R2: A lower-range address must have bits [63 : 64-`tsz_lo`] all zero. An upper-range address must have bits [63 : 64-`tsz_hi`] all one. Otherwise the walk ends with fault code 1 and no read. Supported sizes are 16 to 39.
- R3: Level L reads its descriptor at `table base + 8*index`. The index is VA[47:39], VA[38:30], VA[29:21] or VA[20:12] for levels 0 to 3. The first base comes from R1. Each later base is the previous descriptor's bits [47:12] with 12 zero bits appended.
- R4: A descriptor with bit 0 clear ends the walk with fault code 2 (translation) at its level. A descriptor with bits [1:0] = 11 at levels 0 to 2 is a table pointer.
- R5: Bits [1:0] = 01 at level 1 ends the walk after 2 reads with PA = {desc[47:30], VA[29:0]}. At level 2 it ends after 3 reads with PA = {desc[47:21], VA[20:0]}.
- R6: Bits [1:0] = 11 at level 3 is a page with PA = {desc[47:12], VA[11:0]}, after 4 reads. Bits [1:0] = 01 at level 0 or level 3 gives fault code 2 at that level.
- R7: A block or page with bit 10 clear gives fault code 3 (access flag) at its level instead of a translation. Bit 10 of a table pointer has no effect.
- R8: Descriptor bits [63:48] have no effect on any read address or on the physical address.
- R9: Each read is one single-cycle `mem_req` pulse. The next read is issued only after the previous response. A walk makes at most 4 reads.
- R10: `done` is a one-cycle pulse. On success `ok`=1 and `fault`=0. On a fault `ok`=0 and `pa`=0. `desc` carries the last descriptor read, or 0 after an R1/R2 fault. All results hold until the next walk ends.
- R11: A `start` pulse while `busy` is high is ignored. The walk in progress reads the same addresses and returns the same result.
- R12: After reset `busy`, `done`, `ok` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a walk of `va` (ignored while busy) |
| va | input | 64 | Virtual address to translate |
| tsz_lo | input | 6 | Lower range size field: range is 2^(64-tsz_lo) bytes |
| tsz_hi | input | 6 | Upper range size field |
| base_lo | input | 48 | Level-0 table base for the lower range |
| base_hi | input | 48 | Level-0 table base for the upper range |
| busy | output | 1 | Walk in progress |
| mem_req | output | 1 | One-cycle descriptor read request |
| mem_addr | output | 48 | Descriptor read address |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_data | input | 64 | Descriptor returned by memory |
| done | output | 1 | One-cycle end-of-walk pulse |
| ok | output | 1 | Translation succeeded |
| pa | output | 48 | Physical address (0 on fault) |
| desc | output | 64 | Final descriptor |
| fault | output | 2 | 0 none, 1 address size, 2 translation, 3 access flag |
| fault_lvl | output | 2 | Level at which the fault was found |

## Verification
The hardest cases to reach are the combinations of descriptor type and level: a block at level 0 or 3, an invalid entry at each depth, and a cleared access flag on a block versus on a table. Each needs a specific chain of tables in memory that leads to exactly that level. The bench builds these chains in a behavioural memory. It computes every table index from the virtual address, so one sweep covers many index and offset values. Response latency varies from read to read. A second request is injected during a live walk to show that it does not disturb the walk in progress.

// File: rtl/ptw_pkg.sv
`timescale 1ns/1ps
package ptw_pkg;
    typedef enum logic [1:0] {
        FLT_NONE  = 2'd0,
        FLT_ASIZE = 2'd1,
        FLT_XLAT  = 2'd2,
        FLT_AF    = 2'd3
    } flt_e;

    typedef enum logic [1:0] {
        DK_BAD   = 2'd0,
        DK_TABLE = 2'd1,
        DK_LEAF  = 2'd2
    } dkind_e;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_WAIT = 1'b1
    } wst_e;
endpackage

// File: rtl/ptw_range_check.sv
`timescale 1ns/1ps
module ptw_range_check #(
    parameter int VA_W = 64,
    parameter int SZ_W = 6
) (
    input  logic [VA_W-1:0] va,
    input  logic [SZ_W-1:0] tsz_lo,
    input  logic [SZ_W-1:0] tsz_hi,
    output logic            in_range,
    output logic            use_hi
);
    localparam int SH_W = SZ_W + 1;

    logic [SH_W-1:0] sh_lo, sh_hi;
    logic [7:0]      top;
    logic            lo_fit, hi_fit;

    always_comb begin
        top    = va[VA_W-1 -: 8];
        sh_lo  = SH_W'(VA_W) - {1'b0, tsz_lo};
        sh_hi  = SH_W'(VA_W) - {1'b0, tsz_hi};
        lo_fit = (top == 8'h00) && ((va >> sh_lo) == '0);
        hi_fit = (top == 8'hFF) && (((~va) >> sh_hi) == '0);
        in_range = lo_fit || hi_fit;
        use_hi   = (top == 8'hFF);
    end
endmodule

// File: rtl/ptw_index_sel.sv
`timescale 1ns/1ps
module ptw_index_sel #(
    parameter int VA_W  = 64,
    parameter int PA_W  = 48,
    parameter int LVL   = 4,
    parameter int IDX_W = 9,
    parameter int PG_SH = 12,
    parameter int LVL_W = 2
) (
    input  logic [VA_W-1:0]  va,
    input  logic [LVL_W-1:0] lvl,
    input  logic [PA_W-1:0]  base,
    output logic [PA_W-1:0]  rd_addr
);
    localparam int DESC_SH = 3;

    logic [IDX_W-1:0] idx_of [LVL];
    logic [IDX_W-1:0] idx;

    for (genvar l = 0; l < LVL; l++) begin : g_idx
        localparam int LO = PG_SH + IDX_W * (LVL - 1 - l);
        assign idx_of[l] = va[LO +: IDX_W];
    end

    always_comb begin
        idx = '0;
        for (int l = 0; l < LVL; l++) begin
            if (lvl == LVL_W'(l)) idx = idx_of[l];
        end
        rd_addr = base + PA_W'({idx, {DESC_SH{1'b0}}});
    end
endmodule

// File: rtl/ptw_desc_decode.sv
`timescale 1ns/1ps
module ptw_desc_decode
    import ptw_pkg::*;
#(
    parameter int VA_W  = 64,
    parameter int PA_W  = 48,
    parameter int LVL   = 4,
    parameter int IDX_W = 9,
    parameter int PG_SH = 12,
    parameter int LVL_W = 2,
    parameter int AF_BIT = 10
) (
    input  logic [63:0]      d,
    input  logic [LVL_W-1:0] lvl,
    input  logic [VA_W-1:0]  va,
    output dkind_e           kind,
    output logic             af_set,
    output logic [PA_W-1:0]  leaf_pa,
    output logic [PA_W-1:0]  next_base
);
    logic [PA_W-1:0] keep_mask [LVL];
    logic [PA_W-1:0] mask;
    logic            last_lvl, blk_lvl;

    for (genvar l = 0; l < LVL; l++) begin : g_mask
        localparam int OFF = PG_SH + IDX_W * (LVL - 1 - l);
        assign keep_mask[l] = (PA_W'(1) << OFF) - PA_W'(1);
    end

    always_comb begin
        last_lvl = (lvl == LVL_W'(LVL - 1));
        blk_lvl  = (lvl != '0) && !last_lvl;
        if (!d[0])       kind = DK_BAD;
        else if (d[1])   kind = last_lvl ? DK_LEAF : DK_TABLE;
        else             kind = blk_lvl ? DK_LEAF : DK_BAD;

        mask = '0;
        for (int l = 0; l < LVL; l++) begin
            if (lvl == LVL_W'(l)) mask = keep_mask[l];
        end
        af_set    = d[AF_BIT];
        leaf_pa   = (d[PA_W-1:0] & ~mask) | (va[PA_W-1:0] & mask);
        next_base = {d[PA_W-1:PG_SH], {PG_SH{1'b0}}};
    end
endmodule

// File: rtl/pt_walker.sv
`timescale 1ns/1ps
module pt_walker
    import ptw_pkg::*;
#(
    parameter int VA_W  = 64,
    parameter int PA_W  = 48,
    parameter int LVL   = 4,
    parameter int IDX_W = 9,
    parameter int PG_SH = 12,
    parameter int SZ_W  = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [63:0]     va,
    input  logic [5:0]      tsz_lo,
    input  logic [5:0]      tsz_hi,
    input  logic [47:0]     base_lo,
    input  logic [47:0]     base_hi,
    output logic            busy,
    output logic            mem_req,
    output logic [47:0]     mem_addr,
    input  logic            mem_rsp_valid,
    input  logic [63:0]     mem_rsp_data,
    output logic            done,
    output logic            ok,
    output logic [47:0]     pa,
    output logic [63:0]     desc,
    output logic [1:0]      fault,
    output logic [1:0]      fault_lvl
);
    localparam int LVL_W = $clog2(LVL);

    typedef struct packed {
        wst_e             st;
        logic [LVL_W-1:0] lvl;
        logic [VA_W-1:0]  va;
        logic             req;
        logic [PA_W-1:0]  addr;
        logic             done;
        logic             ok;
        flt_e             flt;
        logic [LVL_W-1:0] flt_lvl;
        logic [PA_W-1:0]  pa;
        logic [63:0]      desc;
    } walk_s;

    walk_s r_d, r_q;

    logic             in_range, use_hi;
    dkind_e           kind;
    logic             af_set;
    logic [PA_W-1:0]  leaf_pa, next_base;
    logic [PA_W-1:0]  sel_base, rd_addr;
    logic [LVL_W-1:0] sel_lvl;
    logic [VA_W-1:0]  sel_va;

    ptw_range_check #(.VA_W(VA_W), .SZ_W(SZ_W)) u_range (
        .va(va), .tsz_lo(tsz_lo), .tsz_hi(tsz_hi),
        .in_range(in_range), .use_hi(use_hi)
    );

    ptw_desc_decode #(
        .VA_W(VA_W), .PA_W(PA_W), .LVL(LVL), .IDX_W(IDX_W),
        .PG_SH(PG_SH), .LVL_W(LVL_W), .AF_BIT(10)
    ) u_dec (
        .d(mem_rsp_data), .lvl(r_q.lvl), .va(r_q.va),
        .kind(kind), .af_set(af_set), .leaf_pa(leaf_pa), .next_base(next_base)
    );

    ptw_index_sel #(
        .VA_W(VA_W), .PA_W(PA_W), .LVL(LVL), .IDX_W(IDX_W),
        .PG_SH(PG_SH), .LVL_W(LVL_W)
    ) u_idx (
        .va(sel_va), .lvl(sel_lvl), .base(sel_base), .rd_addr(rd_addr)
    );

    // Address source: range base on entry, previous descriptor mid-walk.
    always_comb begin
        if (r_q.st == S_IDLE) begin
            sel_va   = va;
            sel_lvl  = '0;
            sel_base = use_hi ? base_hi : base_lo;
        end else begin
            sel_va   = r_q.va;
            sel_lvl  = r_q.lvl + LVL_W'(1);
            sel_base = next_base;
        end
    end

    always_comb begin
        r_d      = r_q;
        r_d.req  = 1'b0;
        r_d.done = 1'b0;
        case (r_q.st)
            S_IDLE: begin
                if (start) begin
                    if (!in_range) begin
                        r_d.done    = 1'b1;
                        r_d.ok      = 1'b0;
                        r_d.flt     = FLT_ASIZE;
                        r_d.flt_lvl = '0;
                        r_d.pa      = '0;
                        r_d.desc    = '0;
                    end else begin
                        r_d.st   = S_WAIT;
                        r_d.lvl  = '0;
                        r_d.va   = va;
                        r_d.req  = 1'b1;
                        r_d.addr = rd_addr;
                    end
                end
            end
            S_WAIT: begin
                if (mem_rsp_valid) begin
                    if (kind == DK_TABLE) begin
                        r_d.lvl  = sel_lvl;
                        r_d.req  = 1'b1;
                        r_d.addr = rd_addr;
                    end else begin
                        r_d.st      = S_IDLE;
                        r_d.done    = 1'b1;
                        r_d.desc    = mem_rsp_data;
                        r_d.flt_lvl = r_q.lvl;
                        if (kind == DK_BAD) begin
                            r_d.ok  = 1'b0;
                            r_d.flt = FLT_XLAT;
                            r_d.pa  = '0;
                        end else if (!af_set) begin
                            r_d.ok  = 1'b0;
                            r_d.flt = FLT_AF;
                            r_d.pa  = '0;
                        end else begin
                            r_d.ok  = 1'b1;
                            r_d.flt = FLT_NONE;
                            r_d.pa  = leaf_pa;
                        end
                    end
                end
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: S_IDLE, flt: FLT_NONE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy      = (r_q.st == S_WAIT);
    assign mem_req   = r_q.req;
    assign mem_addr  = r_q.addr;
    assign done      = r_q.done;
    assign ok        = r_q.ok;
    assign pa        = r_q.pa;
    assign desc      = r_q.desc;
    assign fault     = r_q.flt;
    assign fault_lvl = r_q.flt_lvl;

    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r9_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);
    a_r9_req_in_walk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);
    a_r1_asize_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault == FLT_ASIZE) |-> (fault_lvl == '0 && !$past(mem_req) && desc == '0));
    a_r7_af_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault == FLT_AF) |-> (!desc[10] && desc[0]));
    a_r10_ok_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ok) |-> (fault == FLT_NONE && desc[0] && desc[10]));
    a_r11_va_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(r_q.va));
endmodule

// File: tb/sim_pt_walker.sv
`timescale 1ns/1ps
module sim_pt_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [63:0] va = '0;
    logic [5:0]  tsz_lo = 6'd16, tsz_hi = 6'd25;
    logic [47:0] base_lo = 48'h1000, base_hi = 48'h5000;
    logic        busy, mem_req, done, ok;
    logic [47:0] mem_addr, pa;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic [63:0] desc;
    logic [1:0]  fault, fault_lvl;

    always #5 clk = ~clk;

    pt_walker u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .va(va),
        .tsz_lo(tsz_lo), .tsz_hi(tsz_hi), .base_lo(base_lo), .base_hi(base_hi),
        .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .done(done), .ok(ok), .pa(pa), .desc(desc),
        .fault(fault), .fault_lvl(fault_lvl)
    );

    // Behavioural memory: 8 pages of 512 descriptors, variable latency.
    logic [63:0] mem [0:4095];
    logic [47:0] req_log [0:7];
    int          nreq = 0;
    logic        pend = 1'b0;
    int          cnt = 0;
    logic [47:0] paddr = '0;

    always @(negedge clk) begin
        mem_rsp_valid <= 1'b0;
        if (pend) begin
            if (cnt == 0) begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_data  <= mem[paddr[14:3]];
                pend <= 1'b0;
            end else begin
                cnt <= cnt - 1;
            end
        end
        if (mem_req) begin
            pend  <= 1'b1;
            cnt   <= nreq % 3;
            paddr <= mem_addr;
            req_log[nreq % 8] <= mem_addr;
            nreq  <= nreq + 1;
        end
    end

    int tests = 0, fails = 0;
    logic        r_ok;
    logic [1:0]  r_flt, r_lvl;
    logic [47:0] r_pa;
    logic [63:0] r_desc;
    int          r_base, r_n;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] tbl(input int page);
        return 64'h3 | (64'(page) << 12);
    endfunction
    function automatic logic [63:0] pg(input logic [35:0] oa, input logic af);
        return 64'h3 | (64'(af) << 10) | ({28'h0, oa} << 12);
    endfunction

    task automatic clear_mem();
        for (int k = 0; k < 4096; k++) mem[k] = '0;
    endtask

    task automatic wait_done();
        int w = 0;
        while (!done && w < 300) begin @(negedge clk); w++; end
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL R10 walk never finished actual=0 expected=1");
        end
        r_ok = ok; r_flt = fault; r_lvl = fault_lvl; r_pa = pa; r_desc = desc;
        r_n = nreq - r_base;
    endtask

    task automatic run(input logic [63:0] v);
        @(negedge clk);
        r_base = nreq;
        va = v; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
    endtask

    initial begin
        #1_500_000;
        fails++;
        tests++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        clear_mem();
        repeat (3) @(negedge clk);
        chk("R12 busy", {63'h0, busy}, 64'h0);
        chk("R12 done", {63'h0, done}, 64'h0);
        chk("R12 mem_req", {63'h0, mem_req}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12 ok", {63'h0, ok}, 64'h0);

        // R3 R6 R9: full four-level walks over many indices and offsets
        for (int i = 0; i < 24; i++) begin
            int i0, i1, i2, i3, off;
            logic [35:0] oa;
            logic [63:0] v;
            i0 = (i * 73 + 5) % 512; i1 = (i * 151 + 11) % 512;
            i2 = (i * 29 + 300) % 512; i3 = (i * 97 + 7) % 512;
            off = (i * 933) % 4096;
            oa = 36'(i * 74565 + 2748);
            v = {16'h0, 9'(i0), 9'(i1), 9'(i2), 9'(i3), 12'(off)};
            mem[512 + i0] = tbl(2); mem[1024 + i1] = tbl(3);
            mem[1536 + i2] = tbl(4); mem[2048 + i3] = pg(oa, 1'b1);
            run(v);
            chk("R6 page ok", {63'h0, r_ok}, 64'h1);
            chk("R6 page pa", {16'h0, r_pa}, {16'h0, oa, 12'(off)});
            chk("R10 desc out", r_desc, pg(oa, 1'b1));
            chk("R9 reads", 64'(r_n), 64'd4);
            chk("R3 addr l0", {16'h0, req_log[(r_base + 0) % 8]}, 64'h1000 + 64'(i0 * 8));
            chk("R3 addr l1", {16'h0, req_log[(r_base + 1) % 8]}, 64'h2000 + 64'(i1 * 8));
            chk("R3 addr l2", {16'h0, req_log[(r_base + 2) % 8]}, 64'h3000 + 64'(i2 * 8));
            chk("R3 addr l3", {16'h0, req_log[(r_base + 3) % 8]}, 64'h4000 + 64'(i3 * 8));
        end

        // R5: 1 GB and 2 MB blocks
        for (int i = 0; i < 8; i++) begin
            logic [63:0] v;
            logic [17:0] b1;
            logic [26:0] b2;
            v = {16'h0, 9'd3, 9'(i * 41 + 2), 30'(i * 32'h0123_4567)};
            b1 = 18'(i * 977 + 1);
            mem[512 + 3] = tbl(2);
            mem[1024 + (i * 41 + 2)] = 64'h401 | ({46'h0, b1} << 30);
            run(v);
            chk("R5 l1 block pa", {16'h0, r_pa}, {16'h0, b1, v[29:0]});
            chk("R5 l1 reads", 64'(r_n), 64'd2);
            b2 = 27'(i * 12345 + 9);
            mem[1024 + (i * 41 + 2)] = tbl(3);
            mem[1536 + v[29:21]] = 64'h401 | ({37'h0, b2} << 21);
            run(v);
            chk("R5 l2 block pa", {16'h0, r_pa}, {16'h0, b2, v[20:0]});
            chk("R5 l2 reads", 64'(r_n), 64'd3);
            chk("R5 l2 ok", {62'h0, r_flt}, 64'h0);
        end

        // R4: invalid descriptor at each level
        begin
            logic [63:0] v;
            v = {16'h0, 9'd7, 9'd8, 9'd9, 9'd10, 12'h123};
            mem[512 + 7] = tbl(2); mem[1024 + 8] = tbl(3);
            mem[1536 + 9] = tbl(4); mem[2048 + 10] = pg(36'h55, 1'b1);
            for (int l = 0; l < 4; l++) begin
                logic [63:0] sv;
                int a;
                a = (l + 1) * 512 + 7 + l;
                sv = mem[a];
                mem[a] = 64'hFFFF_FFFF_FFFF_FFFE;
                run(v);
                chk("R4 invalid fault", {62'h0, r_flt}, 64'd2);
                chk("R4 invalid level", {62'h0, r_lvl}, 64'(l));
                chk("R10 fault pa zero", {16'h0, r_pa}, 64'h0);
                chk("R10 fault ok low", {63'h0, r_ok}, 64'h0);
                mem[a] = sv;
            end
            // R6: type 01 at level 0 and level 3
            mem[512 + 7] = 64'h401;
            run(v);
            chk("R6 l0 block fault", {60'h0, r_flt, r_lvl}, {60'h0, 2'd2, 2'd0});
            mem[512 + 7] = tbl(2);
            mem[2048 + 10] = 64'h401 | (64'h55 << 12);
            run(v);
            chk("R6 l3 type01 fault", {60'h0, r_flt, r_lvl}, {60'h0, 2'd2, 2'd3});
            // R7: access flag clear on leaves, ignored on tables
            mem[2048 + 10] = pg(36'h55, 1'b0);
            run(v);
            chk("R7 page af fault", {60'h0, r_flt, r_lvl}, {60'h0, 2'd3, 2'd3});
            chk("R7 af pa zero", {16'h0, r_pa}, 64'h0);
            mem[1536 + 9] = 64'h1 | (64'h7 << 21);
            run(v);
            chk("R7 l2 block af fault", {60'h0, r_flt, r_lvl}, {60'h0, 2'd3, 2'd2});
            mem[1536 + 9] = tbl(4) & ~64'h400;
            mem[512 + 7] = tbl(2) & ~64'h400;
            mem[2048 + 10] = pg(36'h55, 1'b1);
            run(v);
            chk("R7 table af ignored", {16'h0, r_pa}, {16'h0, 36'h55, 12'h123});
            // R8: upper descriptor bits have no effect
            mem[512 + 7] = tbl(2) | 64'hFFFF_0000_0000_0000;
            mem[1024 + 8] = tbl(3) | 64'h000F_0000_0000_0000;
            mem[1536 + 9] = tbl(4) | 64'hA5A5_0000_0000_0000;
            mem[2048 + 10] = pg(36'h55, 1'b1) | 64'hFFFF_0000_0000_0000;
            run(v);
            chk("R8 pa unaffected", {16'h0, r_pa}, {16'h0, 36'h55, 12'h123});
            chk("R8 l3 addr", {16'h0, req_log[(r_base + 3) % 8]}, 64'h4000 + 64'(10 * 8));
            // R10: results hold after done
            repeat (5) @(negedge clk);
            chk("R10 pa held", {16'h0, pa}, {16'h0, 36'h55, 12'h123});
            chk("R10 done low", {63'h0, done}, 64'h0);
            // R11: second start during a walk is ignored
            mem[512 + 7] = tbl(2);
            @(negedge clk);
            r_base = nreq;
            va = v; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            @(negedge clk);
            va = 64'h0012_0000_0000_0000; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            wait_done();
            chk("R11 busy start ignored pa", {16'h0, r_pa}, {16'h0, 36'h55, 12'h123});
            chk("R11 busy start reads", 64'(r_n), 64'd4);
            repeat (4) @(negedge clk);
            chk("R11 no extra walk", 64'(nreq - r_base), 64'd4);
        end

        // R1: upper range base and bad top byte
        begin
            logic [63:0] v;
            v = 64'hFFFF_FF80_0000_0000 | {25'h0, 9'd4, 9'd5, 9'd6, 12'hABC};
            mem[5 * 512 + 511] = tbl(2); mem[1024 + 4] = tbl(3);
            mem[1536 + 5] = tbl(4); mem[2048 + 6] = pg(36'h9_8765_4321, 1'b1);
            run(v);
            chk("R1 upper base addr", {16'h0, req_log[r_base % 8]}, 64'h5FF8);
            chk("R1 upper pa", {16'h0, r_pa}, {16'h0, 36'h9_8765_4321, 12'hABC});
            run(64'h1200_0000_0000_0000);
            chk("R1 bad top fault", {60'h0, r_flt, r_lvl}, {60'h0, 2'd1, 2'd0});
            chk("R1 bad top no read", 64'(r_n), 64'd0);
            chk("R10 asize desc zero", r_desc, 64'h0);
        end

        // R2: range size sweep for both ranges
        for (int t = 16; t < 40; t++) begin
            tsz_lo = 6'(t); tsz_hi = 6'(t);
            run(64'h1 << (63 - t));
            chk("R2 lower inside", {63'h0, r_flt == 2'd1}, 64'h0);
            run(64'h1 << (64 - t));
            chk("R2 lower outside", {62'h0, r_flt}, 64'd1);
            chk("R2 lower no read", 64'(r_n), 64'd0);
            run(~(64'h1 << (63 - t)));
            chk("R2 upper inside", {63'h0, r_flt == 2'd1}, 64'h0);
            run(~(64'h1 << (64 - t)));
            chk("R2 upper outside", {62'h0, r_flt}, 64'd1);
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule